// File: doc/BRIEF.md
# Real-Time Clock Register Front End with Coherent Time Snapshot

This block is the host-side register front end of a real-time clock that also has a small scratch memory. A byte-level serial slave sits in front of it and delivers four kinds of events, one per cycle at most: a write transaction opening, a read transaction opening, a byte arriving from the host and a request for the next byte to send. The block keeps a 6-bit pointer into a 64-byte space. Addresses 0 to 6 are the time registers, address 7 is a control register and addresses 8 to 63 are general-purpose storage.

The clock core presents its live time as seven bytes on `time_in`. Host reads of the time registers do not see that live value. They see a copy frozen at the opening of each read transaction and again whenever the pointer rolls over, so a burst of reads gives one consistent time. Host writes to the time addresses go straight to the clock core through `time_wr_*` and leave the frozen copy as it is. The control register passes only the bits that exist, and its oscillator-fault flag can only be cleared by the host. The clock core sets that flag through `osc_fault_set`.

The sequencer has four states. `ST_IDLE` is the state after reset. `ST_PTR_WAIT` is entered on a write opening, and the next written byte is taken as the pointer. `ST_WRITE` is entered from `ST_PTR_WAIT` when that pointer byte arrives. `ST_READ` is entered on a read opening. A write opening moves any state to `ST_PTR_WAIT` and a read opening moves any state to `ST_READ`. Otherwise the state stays where it is. A written byte outside `ST_PTR_WAIT` is stored at the pointer, and a read request in any state returns the byte at the pointer.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the pointer is 0, every byte of the space reads as 0x00, `ctrl_out` is 0x00, and `rd_valid` and `time_wr_valid` are low.
- R2: The first byte written after `start_wr` loads the pointer with its low 6 bits. That byte is not stored and is not forwarded.
- R3: Each data byte written and each byte read advances the pointer by one, and the pointer wraps from 63 to 0.
- R4: A `rd_req` gives `rd_valid` high with `rd_data` in the next cycle. The byte comes from the snapshot for addresses 0 to 6, from the control register for address 7 and from storage for addresses 8 to 63. `rd_valid` is low in every other cycle.
- R5: `start_rd` copies `time_in` into the snapshot, with byte i at bits 8i+7:8i.
- R6: When the pointer wraps from 63 to 0, `time_in` is copied into the snapshot again.
- R7: A data byte written to address a in 0 to 6 appears on `time_wr_valid`, `time_wr_idx` = a and `time_wr_data` one cycle later. The snapshot is not changed by it.
- R8: A write to the control register stores the data ANDed with 0xB3, so bits 2, 3 and 6 always read as 0.
- R9: On a control write, bit 5 (oscillator fault) keeps its old value if 1 is written and is cleared if 0 is written.
- R10: `osc_fault_set` makes bit 5 equal to 1 in the next cycle, and it wins over a host write in the same cycle.
- R11: `start_wr` or `start_rd` with no data byte following leaves the pointer unchanged.
- R12: A byte written to addresses 8 to 63 reads back unchanged until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Write transaction opens (one-cycle pulse) |
| start_rd | input | 1 | Read transaction opens (one-cycle pulse) |
| wr_valid | input | 1 | A host byte arrives on `wr_data` |
| wr_data | input | 8 | Host byte |
| rd_req | input | 1 | Request for the byte at the pointer |
| time_in | input | 56 | Live time from the clock core, byte i at bits 8i+7:8i |
| osc_fault_set | input | 1 | Clock core reports an oscillator fault |
| rd_valid | output | 1 | `rd_data` holds the requested byte |
| rd_data | output | 8 | Byte returned to the host |
| time_wr_valid | output | 1 | A time field write for the clock core |
| time_wr_idx | output | 3 | Index of the time field being written (0 to 6) |
| time_wr_data | output | 8 | New value for that field |
| ctrl_out | output | 8 | Current control register |

## Verification
The pointer and the sequencer state cannot be seen at the ports. A wrong pointer shows up as a wrong byte on the next `rd_data`, or as a wrong `time_wr_idx`, one cycle after the next transfer. A sequencer stuck in `ST_PTR_WAIT` or leaving it too early shows up as a pointer byte stored as data, or as a data byte taken for an address. A stale or early snapshot shows up only when the time registers are read, so the bench changes `time_in` between the capture events and reads across the 63-to-0 wrap.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PTR_WAIT = 2'd1,
        ST_WRITE    = 2'd2,
        ST_READ     = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rtc_seq.sv
module rtc_seq
    import rtc_regfile_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] ptr_byte,
    input  logic              rd_req,
    output seq_state_e        state,
    output logic [ADDR_W-1:0] ptr,
    output logic              data_wr,
    output logic              data_rd,
    output logic              wrap
);
    seq_state_e state_nx;
    logic       ptr_load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state: a transaction opening overrides whatever state we are in
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PTR_WAIT: if (wr_valid) state_nx = ST_WRITE;
            ST_IDLE, ST_WRITE, ST_READ: state_nx = state;
            default: state_nx = ST_IDLE;
        endcase
        if (start_wr)      state_nx = ST_PTR_WAIT;
        else if (start_rd) state_nx = ST_READ;
    end

    // decoded strobes
    always_comb begin
        ptr_load = wr_valid && (state == ST_PTR_WAIT);
        data_wr  = wr_valid && (state != ST_PTR_WAIT);
        data_rd  = rd_req;
        wrap     = (data_wr || data_rd) && (&ptr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  ptr <= '0;
        else if (ptr_load)           ptr <= ptr_byte;
        else if (data_wr || data_rd) ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] MASK      = 8'hB3,
    parameter int            FAULT_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          fault_set,
    output logic [DW-1:0] ctrl
);
    logic [DW-1:0] ctrl_nx;

    always_comb begin
        ctrl_nx = ctrl;
        if (wr_en) begin
            ctrl_nx            = wr_data & MASK;
            // the fault flag can be cleared by the host but never set
            ctrl_nx[FAULT_BIT] = wr_data[FAULT_BIT] & ctrl[FAULT_BIT];
        end
        if (fault_set) ctrl_nx[FAULT_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else        ctrl <= ctrl_nx;
    end
endmodule

// File: rtl/rtc_scratch.sv
module rtc_scratch #(
    parameter int DW    = 8,
    parameter int DEPTH = 56,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (32'(widx) < DEPTH)) begin
            mem[widx] <= wdata;
        end
    end

    always_comb rdata = (32'(ridx) < DEPTH) ? mem[ridx] : '0;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regfile_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          DW        = 8,
    parameter int          TIME_REGS = 7,
    parameter logic [7:0]  CTRL_MASK = 8'hB3,
    parameter int          FAULT_BIT = 5,
    localparam int         TIDX_W    = $clog2(TIME_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_wr,
    input  logic                    start_rd,
    input  logic                    wr_valid,
    input  logic [DW-1:0]           wr_data,
    input  logic                    rd_req,
    input  logic [TIME_REGS*DW-1:0] time_in,
    input  logic                    osc_fault_set,
    output logic                    rd_valid,
    output logic [DW-1:0]           rd_data,
    output logic                    time_wr_valid,
    output logic [TIDX_W-1:0]       time_wr_idx,
    output logic [DW-1:0]           time_wr_data,
    output logic [DW-1:0]           ctrl_out
);
    localparam int NREG      = 1 << ADDR_W;
    localparam int CTRL_ADDR = TIME_REGS;
    localparam int SCR_BASE  = TIME_REGS + 1;
    localparam int SCR_DEPTH = NREG - SCR_BASE;

    seq_state_e        st;
    logic [ADDR_W-1:0] ptr;
    logic              data_wr, data_rd, wrap;
    logic              is_time, is_ctrl;
    logic [ADDR_W-1:0] scr_idx;
    logic [DW-1:0]     scr_rdata;
    logic [DW-1:0]     snap [TIME_REGS];
    logic [DW-1:0]     rd_mux;

    rtc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .wr_valid (wr_valid),
        .ptr_byte (wr_data[ADDR_W-1:0]),
        .rd_req   (rd_req),
        .state    (st),
        .ptr      (ptr),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .wrap     (wrap)
    );

    always_comb begin
        is_time = ptr < ADDR_W'(TIME_REGS);
        is_ctrl = ptr == ADDR_W'(CTRL_ADDR);
        scr_idx = ptr - ADDR_W'(SCR_BASE);
    end

    rtc_ctrl_reg #(.DW(DW), .MASK(CTRL_MASK), .FAULT_BIT(FAULT_BIT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr && is_ctrl),
        .wr_data   (wr_data),
        .fault_set (osc_fault_set),
        .ctrl      (ctrl_out)
    );

    rtc_scratch #(.DW(DW), .DEPTH(SCR_DEPTH), .IDX_W(ADDR_W)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (data_wr && !is_time && !is_ctrl),
        .widx  (scr_idx),
        .wdata (wr_data),
        .ridx  (scr_idx),
        .rdata (scr_rdata)
    );

    // snapshot of the live time: refreshed on a read opening and on wrap
    for (genvar gi = 0; gi < TIME_REGS; gi++) begin : g_snap
        always_ff @(posedge clk) begin
            if (!rst_n)                snap[gi] <= '0;
            else if (start_rd || wrap) snap[gi] <= time_in[gi*DW +: DW];
        end
    end

    always_comb begin
        if (is_time)      rd_mux = snap[ptr[TIDX_W-1:0]];
        else if (is_ctrl) rd_mux = ctrl_out;
        else              rd_mux = scr_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid      <= 1'b0;
            rd_data       <= '0;
            time_wr_valid <= 1'b0;
            time_wr_idx   <= '0;
            time_wr_data  <= '0;
        end else begin
            rd_valid      <= data_rd;
            if (data_rd) rd_data <= rd_mux;
            time_wr_valid <= data_wr && is_time;
            if (data_wr && is_time) begin
                time_wr_idx  <= ptr[TIDX_W-1:0];
                time_wr_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
    import rtc_regfile_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter int         DW        = 8,
    parameter int         TIME_REGS = 7,
    parameter logic [7:0] CTRL_MASK = 8'hB3,
    parameter int         FAULT_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_wr,
    input logic              start_rd,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] ptr_byte,
    input logic              rd_req,
    input logic              osc_fault_set,
    input logic              rd_valid,
    input logic              time_wr_valid,
    input logic [DW-1:0]     ctrl_out,
    input seq_state_e        st,
    input logic [ADDR_W-1:0] ptr
);
    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && st == ST_PTR_WAIT) |=> (ptr == $past(ptr_byte)));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_valid && st != ST_PTR_WAIT) || rd_req) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R4
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R4
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R7
    tw_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr_valid |-> ($past(wr_valid) && $past(st) != ST_PTR_WAIT
                           && $past(ptr) < ADDR_W'(TIME_REGS)));

    // R8
    ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_out & ~CTRL_MASK) == '0);

    // R10
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fault_set |=> ctrl_out[FAULT_BIT]);

    // R11
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr || start_rd) |=> $stable(ptr));
endmodule

bind rtc_regfile rtc_regfile_chk #(
    .ADDR_W(ADDR_W), .DW(DW), .TIME_REGS(TIME_REGS),
    .CTRL_MASK(CTRL_MASK), .FAULT_BIT(FAULT_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_wr      (start_wr),
    .start_rd      (start_rd),
    .wr_valid      (wr_valid),
    .ptr_byte      (wr_data[ADDR_W-1:0]),
    .rd_req        (rd_req),
    .osc_fault_set (osc_fault_set),
    .rd_valid      (rd_valid),
    .time_wr_valid (time_wr_valid),
    .ctrl_out      (ctrl_out),
    .st            (st),
    .ptr           (ptr)
);

// File: tb/tb_rtc_regfile.sv
module tb_rtc_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr = 0, start_rd = 0, wr_valid = 0, rd_req = 0, osc_fault_set = 0;
    logic [7:0]  wr_data = '0;
    logic [55:0] time_in = '0;
    logic        rd_valid, time_wr_valid;
    logic [7:0]  rd_data, time_wr_data, ctrl_out;
    logic [2:0]  time_wr_idx;

    int n_chk = 0, n_err = 0;

    // reference model state
    int m_mem [64];
    int m_snap [7];
    int m_ptr, m_ctrl;
    bit m_pend;
    bit e_rv, e_tv;
    int e_rd, e_tidx, e_tdat;

    always #4 clk = ~clk;

    rtc_regfile dut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .time_in(time_in),
        .osc_fault_set(osc_fault_set), .rd_valid(rd_valid), .rd_data(rd_data),
        .time_wr_valid(time_wr_valid), .time_wr_idx(time_wr_idx),
        .time_wr_data(time_wr_data), .ctrl_out(ctrl_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    task automatic m_capture();
        for (int i = 0; i < 7; i++) m_snap[i] = int'(time_in[i*8 +: 8]);
    endtask

    task automatic m_advance();
        m_ptr = (m_ptr + 1) % 64;
        if (m_ptr == 0) m_capture();
    endtask

    task automatic m_reset();
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        for (int i = 0; i < 7; i++) m_snap[i] = 0;
        m_ptr = 0; m_ctrl = 0; m_pend = 0;
    endtask

    // one clock: drive the events, step the model, compare after the edge
    task automatic step(input bit sw, input bit sr, input bit wv, input int wd,
                        input bit rr, input bit fs, input string tag);
        @(negedge clk);
        start_wr = sw; start_rd = sr; wr_valid = wv; wr_data = 8'(wd);
        rd_req = rr; osc_fault_set = fs;
        e_rv = 0; e_tv = 0;
        if (sw) m_pend = 1;
        else if (sr) begin m_pend = 0; m_capture(); end
        else if (wv) begin
            if (m_pend) begin m_ptr = wd % 64; m_pend = 0; end
            else begin
                if (m_ptr < 7) begin e_tv = 1; e_tidx = m_ptr; e_tdat = wd; end
                else if (m_ptr == 7) m_ctrl = (wd & 'h93) | (wd & m_ctrl & 'h20);
                else m_mem[m_ptr] = wd;
                m_advance();
            end
        end else if (rr) begin
            e_rv = 1;
            e_rd = (m_ptr < 7) ? m_snap[m_ptr] : (m_ptr == 7) ? m_ctrl : m_mem[m_ptr];
            m_advance();
        end
        if (fs) m_ctrl = m_ctrl | 'h20;
        @(posedge clk);
        #1;
        start_wr = 0; start_rd = 0; wr_valid = 0; rd_req = 0; osc_fault_set = 0;
        check(rd_valid == e_rv, tag, "rd_valid", int'(rd_valid), int'(e_rv));
        if (e_rv) check(int'(rd_data) == e_rd, tag, "rd_data", int'(rd_data), e_rd);
        check(time_wr_valid == e_tv, tag, "time_wr_valid", int'(time_wr_valid), int'(e_tv));
        if (e_tv) begin
            check(int'(time_wr_idx) == e_tidx, tag, "time_wr_idx", int'(time_wr_idx), e_tidx);
            check(int'(time_wr_data) == e_tdat, tag, "time_wr_data", int'(time_wr_data), e_tdat);
        end
        check(int'(ctrl_out) == m_ctrl, tag, "ctrl_out", int'(ctrl_out), m_ctrl);
    endtask

    task automatic set_ptr(input int a, input string tag);
        step(1, 0, 0, 0, 0, 0, tag);
        step(0, 0, 1, a, 0, 0, tag);
    endtask

    task automatic wr(input int d, input string tag);
        step(0, 0, 1, d, 0, 0, tag);
    endtask

    task automatic rd(input string tag);
        step(0, 0, 0, 0, 1, 0, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        m_reset();
        time_in = 56'h07_06_05_04_03_02_01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check(rd_valid == 0, "R1", "rd_valid", int'(rd_valid), 0);
        check(time_wr_valid == 0, "R1", "time_wr_valid", int'(time_wr_valid), 0);
        check(ctrl_out == 0, "R1", "ctrl_out", int'(ctrl_out), 0);

        // R1 R5: read the whole space from pointer 0 (snapshot taken at start_rd)
        step(0, 1, 0, 0, 0, 0, "R5");
        time_in = 56'h99_88_77_66_55_44_33;
        for (int i = 0; i < 64; i++) rd("R1");
        // R6: the wrap above captured the new time
        for (int i = 0; i < 7; i++) rd("R6");

        // R8 R9 R10: control register
        set_ptr('hC7, "R2");
        wr('hFF, "R8");
        step(0, 0, 0, 0, 0, 1, "R10");
        set_ptr(7, "R9");
        wr('hFF, "R9");
        set_ptr(7, "R9");
        wr('h00, "R9");
        set_ptr(7, "R10");
        step(0, 0, 1, 'h00, 0, 1, "R10");
        set_ptr(7, "R4");
        rd("R4");

        // R2: the pointer byte is not stored
        set_ptr('h48, "R2");
        rd("R2");
        // R12: storage write and readback
        set_ptr(8, "R12");
        wr('hA5, "R12");
        wr('h5A, "R12");
        set_ptr('h88, "R12");
        rd("R12");
        rd("R12");

        // R7: time writes are forwarded, snapshot stays
        set_ptr(0, "R7");
        for (int i = 0; i < 7; i++) wr('h11 * (i + 1), "R7");
        set_ptr(0, "R7");
        for (int i = 0; i < 7; i++) rd("R7");

        // R3 R6: writes wrap from 63 into the time registers
        set_ptr(62, "R3");
        time_in = 56'h12_34_56_78_9A_BC_DE;
        wr('h3C, "R3");
        wr('hC3, "R3");
        wr('h21, "R3");
        set_ptr(62, "R6");
        time_in = 56'h01_02_03_04_05_06_07;
        rd("R6"); rd("R6"); rd("R6"); rd("R6");

        // R11: openings without data keep the pointer
        set_ptr(20, "R11");
        step(1, 0, 0, 0, 0, 0, "R11");
        step(0, 1, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, "R11");
        rd("R11");

        // R3 R4 R12: random traffic
        for (int it = 0; it < 4000; it++) begin
            int r;
            r = $urandom % 10;
            if (($urandom % 8) == 0) time_in = {$urandom, $urandom};
            case (r)
                0: step(1, 0, 0, 0, 0, ($urandom % 16) == 0, "R3 R4 R12");
                1: step(0, 1, 0, 0, 0, ($urandom % 16) == 0, "R3 R4 R12");
                2, 3, 4: step(0, 0, 1, $urandom % 256, 0, ($urandom % 16) == 0, "R3 R4 R12");
                5, 6, 7: step(0, 0, 0, 0, 1, ($urandom % 16) == 0, "R3 R4 R12");
                default: step(0, 0, 0, 0, 0, ($urandom % 16) == 0, "R3 R4 R12");
            endcase
        end

        summary();
        $finish;
    end
endmodule